// File: doc/BRIEF.md
# Auxiliary-Channel Request Framer

This block turns one auxiliary-channel request into the ordered byte sequence a serial transmitter sends. A single start pulse captures a 4-bit command, a 20-bit target address, a transfer length of 0 to 16, a transaction type (native or I2C-over-AUX), an action code and up to 16 payload bytes. The block then presents the header bytes, an optional length byte and, for writes only, the payload bytes on a valid/ready byte stream.

Once the last byte has been accepted, the block acknowledges the transmitter's completion flag from the previous transfer. It waits for that flag to drop, then issues a one-cycle launch pulse. The total byte count and a programmable start delay are presented alongside the pulse. If the flag never drops within a bounded number of cycles, the block gives up and pulses a timeout output instead of launching.

Top module: `aux_req_framer`

## Requirements
- R1: After reset, busyOut, txValid, goOut, doneAckOut and timeoutOut are all 0.
- R2: The first three bytes sent are {cmdIn, addrIn[19:16]} (command in bits 7:4), then addrIn[15:8], then addrIn[7:0].
- R3: When lenIn is non-zero, the fourth byte is lenIn minus 1; when lenIn is 0, no length byte is sent.
- R4: The request is a write when typeIn=0 (native) and actionIn=0, or when typeIn=1 (I2C) and actionIn is 0 (write) or 2 (write, transaction continues); every other type/action pair sends no payload.
- R5: For a write, payload bytes 0 to lenIn-1 (byte i taken from payloadIn[8*i+7:8*i]) follow the header in index order.
- R6: While goOut is high, byteCount equals 3 (zero length) or 4 (non-zero length), plus lenIn for writes, and startDelayOut equals the delayIn value captured at start.
- R7: While txValid is high and txReady is low, txValid stays high and txData holds its value on the next cycle.
- R8: After the last byte is accepted, doneAckOut pulses for one cycle; goOut pulses for exactly one cycle, and only after doneFlagIn has been seen low.
- R9: If doneFlagIn stays high for TIMEOUT cycles of waiting, timeoutOut pulses once and goOut is not issued.
- R10: busyOut is high from the cycle after an accepted start until the cycle after goOut or timeoutOut; a start pulse seen while busy is ignored and does not alter the request in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Request start pulse |
| cmdIn | input | 4 | Command code |
| addrIn | input | 20 | Target address |
| lenIn | input | LEN_W | Transfer length, 0 to MAX_LEN |
| typeIn | input | 1 | 0 native, 1 I2C-over-AUX |
| actionIn | input | 3 | 0 write, 1 read, 2 write with transaction continuing, 3 read with transaction continuing, others non-data |
| delayIn | input | DELAY_W | Start delay to hand to the transmitter |
| payloadIn | input | MAX_LEN*8 | Write payload, byte i at bits 8*i+7:8*i |
| txData | output | 8 | Stream byte |
| txValid | output | 1 | Stream byte valid |
| txReady | input | 1 | Transmitter accepts byte |
| byteCount | output | CNT_W | Total bytes in the request |
| startDelayOut | output | DELAY_W | Captured start delay |
| doneAckOut | output | 1 | Acknowledge pulse for the previous done flag |
| doneFlagIn | input | 1 | Transmitter done flag from the previous transfer |
| goOut | output | 1 | Launch pulse |
| timeoutOut | output | 1 | Done flag failed to clear in time |
| busyOut | output | 1 | Request in progress |

## Verification
The timeout path is the hardest state to reach from the ports, because the done flag normally clears within a few cycles of its acknowledge. The bench models the transmitter's flag itself: in most runs it clears the flag a random 0 to 2 cycles after the acknowledge, and in one directed run it holds the flag high. A second situation that needs deliberate stimulus is a start pulse that arrives while a request is in flight with altered command, address and length. The bench injects one mid-stream and then compares the full byte sequence against the original request. Random backpressure on txReady exercises the hold behaviour at every byte position, including the header and length bytes.

// File: rtl/aux_framer_pkg.sv
package aux_framer_pkg;
  localparam int CMD_W  = 4;
  localparam int ADDR_W = 20;

  localparam logic       TYPE_NATIVE   = 1'b0;
  localparam logic       TYPE_I2C      = 1'b1;
  localparam logic [2:0] ACT_WRITE     = 3'd0;
  localparam logic [2:0] ACT_READ      = 3'd1;
  localparam logic [2:0] ACT_WRITE_MOT = 3'd2;
  localparam logic [2:0] ACT_READ_MOT  = 3'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_ACK, ST_WAIT, ST_LAUNCH, ST_FAIL
  } framerState_t;

  typedef struct packed {
    logic capture;
    logic advance;
  } dpStrobe_t;
endpackage

// File: rtl/aux_framer_dp.sv
module aux_framer_dp
  import aux_framer_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int DELAY_W = 8,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int CNT_W   = $clog2(MAX_LEN + 5)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic                   busy,
  input  logic [CMD_W-1:0]       cmdIn,
  input  logic [ADDR_W-1:0]      addrIn,
  input  logic [LEN_W-1:0]       lenIn,
  input  logic                   typeIn,
  input  logic [2:0]             actionIn,
  input  logic [DELAY_W-1:0]     delayIn,
  input  logic [MAX_LEN*8-1:0]   payloadIn,
  output logic [7:0]             txData,
  output logic                   lastByte,
  output logic [CNT_W-1:0]       byteCount,
  output logic [DELAY_W-1:0]     startDelay
);
  localparam int PI_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic [CMD_W-1:0]   cmdQ;
  logic [ADDR_W-1:0]  addrQ;
  logic [LEN_W-1:0]   lenQ;
  logic               writeQ;
  logic [DELAY_W-1:0] delayQ;
  logic [CNT_W-1:0]   idxQ;
  logic [7:0]         payQ [MAX_LEN];
  logic               isWrite;
  logic [CNT_W-1:0]   hdrLen;
  logic [PI_W-1:0]    payIdx;

  assign isWrite = (actionIn == ACT_WRITE) ||
                   ((typeIn == TYPE_I2C) && (actionIn == ACT_WRITE_MOT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ   <= '0;
      addrQ  <= '0;
      lenQ   <= '0;
      writeQ <= 1'b0;
      delayQ <= '0;
    end else if (strobe.capture) begin
      cmdQ   <= cmdIn;
      addrQ  <= addrIn;
      lenQ   <= lenIn;
      writeQ <= isWrite;
      delayQ <= delayIn;
    end
  end

  for (genvar gi = 0; gi < MAX_LEN; gi++) begin : g_pay
    always_ff @(posedge clk) begin
      if (!rstN)               payQ[gi] <= '0;
      else if (strobe.capture) payQ[gi] <= payloadIn[8*gi +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               idxQ <= '0;
    else if (strobe.capture) idxQ <= '0;
    else if (strobe.advance) idxQ <= idxQ + CNT_W'(1);
  end

  assign hdrLen    = (lenQ != '0) ? CNT_W'(4) : CNT_W'(3);
  assign byteCount = hdrLen + (writeQ ? CNT_W'(lenQ) : CNT_W'(0));
  assign lastByte  = (idxQ == byteCount - CNT_W'(1));
  assign startDelay = delayQ;
  assign payIdx    = PI_W'(idxQ - CNT_W'(4));

  always_comb begin
    if (idxQ == CNT_W'(0))      txData = {cmdQ, addrQ[19:16]};
    else if (idxQ == CNT_W'(1)) txData = addrQ[15:8];
    else if (idxQ == CNT_W'(2)) txData = addrQ[7:0];
    else if (idxQ == CNT_W'(3)) txData = 8'(lenQ) - 8'd1;
    else                        txData = payQ[payIdx];
  end

  // R10: captured request is frozen while busy
  p_fields_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.capture) |=> ($stable(cmdQ) && $stable(addrQ) && $stable(lenQ) && $stable(writeQ)));

  // R5: stream index never passes the total byte count
  p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (idxQ <= byteCount));

  // R6: total count lies in the legal header+payload range
  p_count_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ((int'(byteCount) >= 3) && (int'(byteCount) <= MAX_LEN + 4)));
endmodule

// File: rtl/aux_framer_ctl.sv
module aux_framer_ctl
  import aux_framer_pkg::*;
#(
  parameter int TIMEOUT = 256,
  parameter int TW      = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startIn,
  input  logic      txReady,
  input  logic      lastByte,
  input  logic      doneFlagIn,
  output dpStrobe_t strobe,
  output logic      txValid,
  output logic      doneAck,
  output logic      go,
  output logic      timeout,
  output logic      busy
);
  framerState_t stateQ, stateD;
  logic [TW-1:0] timerQ;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (startIn) stateD = ST_SEND;
      ST_SEND:   if (txReady && lastByte) stateD = ST_ACK;
      ST_ACK:    stateD = ST_WAIT;
      ST_WAIT: begin
        if (!doneFlagIn)                       stateD = ST_LAUNCH;
        else if (timerQ == TW'(TIMEOUT - 1))   stateD = ST_FAIL;
      end
      ST_LAUNCH: stateD = ST_IDLE;
      ST_FAIL:   stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 timerQ <= '0;
    else if (stateQ != ST_WAIT) timerQ <= '0;
    else                        timerQ <= timerQ + TW'(1);
  end

  assign strobe.capture = (stateQ == ST_IDLE) && startIn;
  assign strobe.advance = (stateQ == ST_SEND) && txReady;
  assign txValid = (stateQ == ST_SEND);
  assign doneAck = (stateQ == ST_ACK);
  assign go      = (stateQ == ST_LAUNCH);
  assign timeout = (stateQ == ST_FAIL);
  assign busy    = (stateQ != ST_IDLE);

  // R7: a stalled byte stays offered
  p_valid_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> txValid);

  // R8: launch only after the done flag was seen low
  p_go_after_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    go |-> $past(!doneFlagIn));

  // R8: launch is a single pulse that ends the request
  p_go_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    go |=> (!go && !busy));

  // R8: acknowledge is a single pulse
  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneAck |=> !doneAck);

  // R9: timeout only when the flag was still high
  p_timeout_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> $past(doneFlagIn));

  // R9: timeout and launch never coincide
  p_go_xor_timeout_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(go && timeout));
endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
  import aux_framer_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int DELAY_W = 8,
  parameter int TIMEOUT = 256,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int CNT_W   = $clog2(MAX_LEN + 5)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startIn,
  input  logic [3:0]           cmdIn,
  input  logic [19:0]          addrIn,
  input  logic [LEN_W-1:0]     lenIn,
  input  logic                 typeIn,
  input  logic [2:0]           actionIn,
  input  logic [DELAY_W-1:0]   delayIn,
  input  logic [MAX_LEN*8-1:0] payloadIn,
  output logic [7:0]           txData,
  output logic                 txValid,
  input  logic                 txReady,
  output logic [CNT_W-1:0]     byteCount,
  output logic [DELAY_W-1:0]   startDelayOut,
  output logic                 doneAckOut,
  input  logic                 doneFlagIn,
  output logic                 goOut,
  output logic                 timeoutOut,
  output logic                 busyOut
);
  dpStrobe_t strobe;
  logic      lastByte;

  aux_framer_ctl #(.TIMEOUT(TIMEOUT)) u_ctl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .txReady(txReady),
    .lastByte(lastByte), .doneFlagIn(doneFlagIn), .strobe(strobe),
    .txValid(txValid), .doneAck(doneAckOut), .go(goOut),
    .timeout(timeoutOut), .busy(busyOut)
  );

  aux_framer_dp #(.MAX_LEN(MAX_LEN), .DELAY_W(DELAY_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busyOut),
    .cmdIn(cmdIn), .addrIn(addrIn), .lenIn(lenIn), .typeIn(typeIn),
    .actionIn(actionIn), .delayIn(delayIn), .payloadIn(payloadIn),
    .txData(txData), .lastByte(lastByte), .byteCount(byteCount),
    .startDelay(startDelayOut)
  );

  // R7: stalled byte value does not change
  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> $stable(txData));

  // R1: idle outputs quiet while not busy
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busyOut |-> (!txValid && !goOut && !doneAckOut && !timeoutOut));
endmodule

// File: tb/sim_aux_req_framer.sv
module sim_aux_req_framer;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN = 16;
  localparam int DELAY_W = 8;
  localparam int TIMEOUT = 40;
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int CNT_W = $clog2(MAX_LEN + 5);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [3:0] cmdIn = '0;
  logic [19:0] addrIn = '0;
  logic [LEN_W-1:0] lenIn = '0;
  logic typeIn = 1'b0;
  logic [2:0] actionIn = '0;
  logic [DELAY_W-1:0] delayIn = '0;
  logic [MAX_LEN*8-1:0] payloadIn = '0;
  logic [7:0] txData;
  logic txValid;
  logic txReady = 1'b0;
  logic [CNT_W-1:0] byteCount;
  logic [DELAY_W-1:0] startDelayOut;
  logic doneAckOut;
  logic doneFlagIn = 1'b0;
  logic goOut, timeoutOut, busyOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  aux_req_framer #(.MAX_LEN(MAX_LEN), .DELAY_W(DELAY_W), .TIMEOUT(TIMEOUT)) u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .cmdIn(cmdIn), .addrIn(addrIn),
    .lenIn(lenIn), .typeIn(typeIn), .actionIn(actionIn), .delayIn(delayIn),
    .payloadIn(payloadIn), .txData(txData), .txValid(txValid), .txReady(txReady),
    .byteCount(byteCount), .startDelayOut(startDelayOut), .doneAckOut(doneAckOut),
    .doneFlagIn(doneFlagIn), .goOut(goOut), .timeoutOut(timeoutOut), .busyOut(busyOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit expWrite(input bit typ, input logic [2:0] act);
    if (act == 3'd0) return 1'b1;
    if (typ && act == 3'd2) return 1'b1;
    return 1'b0;
  endfunction

  task automatic runReq(input logic [3:0] cmd, input logic [19:0] addr, input int len,
                        input bit typ, input logic [2:0] act, input logic [7:0] dly,
                        input int rdyPct, input bit stuck, input bit poke);
    logic [MAX_LEN*8-1:0] pay;
    logic [7:0] expB [32];
    logic [7:0] gotB [32];
    int expN, gotN, n, clearIn;
    bit wr, pendHold, ackSeen, goSeen, toSeen, done, rdy;
    logic [7:0] holdData;
    string rq;

    for (int i = 0; i < MAX_LEN; i++) pay[8*i +: 8] = 8'($urandom);
    wr = expWrite(typ, act);
    expB[0] = {cmd, addr[19:16]};
    expB[1] = addr[15:8];
    expB[2] = addr[7:0];
    expN = 3;
    if (len != 0) begin
      expB[3] = 8'(len - 1);
      expN = 4;
    end
    if (wr) for (int i = 0; i < len; i++) begin
      expB[expN] = pay[8*i +: 8];
      expN++;
    end

    @(negedge clk);
    cmdIn = cmd; addrIn = addr; lenIn = LEN_W'(len); typeIn = typ;
    actionIn = act; delayIn = dly; payloadIn = pay;
    startIn = 1'b1;
    doneFlagIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    chk(busyOut == 1'b1, "R10", "busy after start", int'(busyOut), 1);

    gotN = 0; n = 0; clearIn = -1;
    pendHold = 0; ackSeen = 0; goSeen = 0; toSeen = 0; done = 0; holdData = '0;
    while (!done && n < 600) begin
      if (pendHold) begin
        chk(txValid == 1'b1, "R7", "valid held", int'(txValid), 1);
        chk(txData == holdData, "R7", "data held", int'(txData), int'(holdData));
      end
      if (txValid) rdy = (($urandom % 100) < rdyPct);
      else         rdy = $urandom % 2;
      if (txValid && rdy && gotN < 32) begin
        gotB[gotN] = txData;
        gotN++;
      end
      pendHold = txValid && !rdy;
      holdData = txData;
      txReady = rdy;
      if (doneAckOut) begin
        ackSeen = 1;
        if (!stuck) clearIn = $urandom % 3;
      end
      if (clearIn == 0) begin
        doneFlagIn = 1'b0;
        clearIn = -1;
      end else if (clearIn > 0) begin
        clearIn--;
      end
      if (goOut) begin
        goSeen = 1;
        done = 1;
        chk(ackSeen && doneFlagIn == 1'b0, "R8", "go after ack and clear",
            int'(doneFlagIn), 0);
        chk(int'(byteCount) == expN, "R6 R4", "byte count", int'(byteCount), expN);
        chk(startDelayOut == dly, "R6", "start delay", int'(startDelayOut), int'(dly));
      end
      if (timeoutOut) begin
        toSeen = 1;
        done = 1;
      end
      if (poke && n == 2 && !done) begin
        startIn = 1'b1;
        cmdIn = ~cmd; addrIn = ~addr; lenIn = LEN_W'(MAX_LEN); actionIn = 3'd0;
      end else begin
        startIn = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    startIn = 1'b0;
    txReady = 1'b0;

    chk(busyOut == 1'b0, "R10", "busy cleared after end", int'(busyOut), 0);
    chk(goOut == 1'b0 && timeoutOut == 1'b0, "R8", "end pulse single", int'(goOut), 0);
    if (stuck) begin
      chk(toSeen && !goSeen, "R9", "timeout without go", int'(toSeen), 1);
    end else begin
      chk(goSeen && !toSeen, "R8", "go issued", int'(goSeen), 1);
    end
    chk(gotN == expN, poke ? "R10" : "R4", "bytes sent", gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++) begin
      if (i < 3) rq = "R2";
      else if (i == 3 && len != 0) rq = "R3";
      else rq = "R5";
      chk(gotB[i] == expB[i], rq, $sformatf("byte %0d", i), int'(gotB[i]), int'(expB[i]));
    end
    doneFlagIn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busyOut == 1'b0, "R1", "busy reset", int'(busyOut), 0);
    chk(txValid == 1'b0, "R1", "valid reset", int'(txValid), 0);
    chk(goOut == 1'b0 && doneAckOut == 1'b0 && timeoutOut == 1'b0, "R1",
        "pulses reset", int'(goOut), 0);

    // R3: zero-length read, header only
    runReq(4'h9, 20'hABCDE, 0, 1'b0, 3'd1, 8'd5, 100, 0, 0);
    // R3 R4: zero-length native write, still three bytes
    runReq(4'h8, 20'h12345, 0, 1'b0, 3'd0, 8'd0, 100, 0, 0);
    // R5: full-length I2C write with transaction continuing
    runReq(4'h4, 20'hF0F0F, MAX_LEN, 1'b1, 3'd2, 8'd200, 60, 0, 0);
    // R4: native action 2 is not a write
    runReq(4'h1, 20'h00001, 5, 1'b0, 3'd2, 8'd7, 80, 0, 0);
    // R4: I2C read, length byte only
    runReq(4'h5, 20'h80000, 1, 1'b1, 3'd1, 8'd3, 100, 0, 0);
    // R5: native write of one byte under heavy backpressure
    runReq(4'h8, 20'h7FFFF, 1, 1'b0, 3'd0, 8'd9, 25, 0, 0);
    // R9: done flag stuck high
    runReq(4'hC, 20'h55555, 3, 1'b1, 3'd0, 8'd1, 100, 1, 0);
    // R10: start pulse while busy is ignored
    runReq(4'h2, 20'h0A0B0, 4, 1'b0, 3'd0, 8'd11, 50, 0, 1);

    for (int k = 0; k < 40; k++) begin
      runReq(4'($urandom), 20'($urandom), int'($urandom % (MAX_LEN + 1)),
             1'($urandom), 3'($urandom % 5), 8'($urandom),
             30 + int'($urandom % 71), 0, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule